// File: doc/BRIEF.md
# Eight-Input Vectored Interrupt Controller

This block collects up to eight interrupt requests from on-chip peripherals, picks the most urgent one, and presents it to a 16-bit processor on its local bus. Requests are latched into a request register, either on a rising edge or as a live level, depending on a configuration bit. When an unmasked request outranks everything already being serviced, the controller raises its interrupt line.

The processor answers with two acknowledge pulses. The first pulse commits the winner: its request bit is cleared, its in-service bit is set, and the controller keeps its data output disabled. The second pulse makes the controller drive an 8-bit vector onto the data bus. The vector carries a programmable 5-bit base in the upper bits and the 3-bit input number in the lower bits. An in-service bit is released either by a nonspecific end-of-interrupt command from software, or automatically when the second pulse ends, if automatic release is configured. If the request vanished before the first pulse, the controller hands out the vector for input 7 and marks nothing as in service.

Software reaches the controller through a small register port: select, read and write strobes (one register access per clock while select and a strobe are high), one address bit and an 8-bit data path, with a separate output-enable in place of a tristate bus.

Top module: `pri_irq_ctrl`

## Requirements
- R1: In edge mode a 0-to-1 change on request input i sets pending bit i one clock later; the bit stays set after the input falls and is not set again while the input merely stays high after being acknowledged.
- R2: In level mode the pending register takes the request inputs' levels every clock, so several inputs high at once are all pending together, and a dropped input clears its pending bit.
- R3: Input 0 has the highest priority and input 7 the lowest. The interrupt output is high exactly when no acknowledge sequence is in progress and some pending, unmasked input has a lower number than every set in-service bit.
- R4: A rising acknowledge while idle starts the first pulse: the winning input's in-service bit is set and its pending bit cleared; the data output-enable stays low for the whole first pulse.
- R5: During the second acknowledge pulse, from its rising clock onward, the output-enable is high and the data output equals {base[4:0], index[2:0]} of the input committed by the first pulse.
- R6: With automatic release on, the committed input's in-service bit clears at the clock where the second pulse falls.
- R7: With automatic release off, in-service bits stay set until a write of 0x40 to address 0, which clears the lowest-numbered set in-service bit only.
- R8: Address 1 holds the mask register, written and read as a byte (bit i masks input i). Masked inputs still become pending but cannot raise the interrupt output.
- R9: A write to address 0 with bit 7 set loads the configuration: bits 4..0 the vector base, bit 5 level mode, bit 6 automatic release. A write to address 0 with bits 7 and 6 clear sets the read selector from bit 0.
- R10: A read (select and read high) drives the output-enable and returns, at address 0, the pending register when the read selector is 0 or the in-service register when it is 1, and at address 1 the mask.
- R11: If no input qualifies at the first pulse, the second pulse returns {base, 3'd7} and the in-service register is left unchanged.
- R12: After reset: nothing pending or in service, all inputs masked (0xFF), base 0, edge mode, automatic release off, read selector 0, interrupt output and output-enable low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req_i | input | 8 | Request inputs, bit 0 most urgent |
| irq_o | output | 1 | Interrupt to the processor |
| ack_i | input | 1 | Acknowledge pulse from the processor, active high |
| bus_cs_i | input | 1 | Register port select |
| bus_rd_i | input | 1 | Register read strobe |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 1 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data or vector |
| bus_oe_o | output | 1 | High when bus_rdata_o must be driven onto the bus |

## Verification
The bench aims at the first acknowledge pulse, where a design that drove the vector early or failed to clear the pending bit would show a bus value or a repeated interrupt; at nested service, where a request equal to or below an in-service level must stay silent and a wrong comparison would raise the interrupt line too soon. It also covers a request that disappears in level mode before acknowledge, where a design without the fallback would return a stale index or mark an input as in service, and a held input in edge mode, which a level-following design would acknowledge twice. End-of-interrupt ordering is checked by stacking two in-service bits and releasing them one by one.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Acknowledge sequence phase
    typedef enum logic [1:0] {
        ACK_IDLE = 2'd0,
        ACK_ONE  = 2'd1,
        ACK_TWO  = 2'd2
    } ack_ph_e;

    // Command byte decoding at address 0
    localparam int CMD_CFG_BIT  = 7;
    localparam int CMD_EOI_BIT  = 6;
    localparam int CFG_AEOI_BIT = 6;
    localparam int CFG_LVL_BIT  = 5;
    localparam int CMD_RSEL_BIT = 0;

endpackage

// File: rtl/irqc_prienc.sv
module irqc_prienc #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  vec_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o,
    output logic [N-1:0]  first_oh_o
);

    // Lowest index wins
    always_comb begin
        found_o    = 1'b0;
        idx_o      = '0;
        first_oh_o = '0;
        for (int i = 0; i < N; i++) begin
            if (vec_i[i] && !found_o) begin
                found_o       = 1'b1;
                idx_o         = IW'(i);
                first_oh_o[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irqc_ackseq.sv
module irqc_ackseq
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ack_i,
    output logic commit_o,
    output logic drive_o,
    output logic finish_o,
    output logic busy_o
);

    typedef struct packed {
        ack_ph_e ph;
        logic    ack;
    } seq_t;

    seq_t s_q, s_d;
    logic rise, fall;

    always_comb begin
        rise     = ack_i & ~s_q.ack;
        fall     = ~ack_i & s_q.ack;
        s_d      = s_q;
        s_d.ack  = ack_i;
        commit_o = 1'b0;
        finish_o = 1'b0;
        case (s_q.ph)
            ACK_IDLE: if (rise) begin
                commit_o = 1'b1;
                s_d.ph   = ACK_ONE;
            end
            ACK_ONE:  if (rise) s_d.ph = ACK_TWO;
            ACK_TWO:  if (fall) begin
                finish_o = 1'b1;
                s_d.ph   = ACK_IDLE;
            end
            default:  s_d.ph = ACK_IDLE;
        endcase
        drive_o = ack_i & ((s_q.ph == ACK_TWO) | ((s_q.ph == ACK_ONE) & rise));
        busy_o  = (s_q.ph != ACK_IDLE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.ph  <= ACK_IDLE;
            s_q.ack <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_TWO_FOLLOWS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == ACK_TWO) |-> ($past(s_q.ph) != ACK_IDLE)); // R5

    AST_COMMIT_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> (s_q.ph == ACK_ONE)); // R4

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int N      = 8,
    parameter int DW     = 8,
    parameter int BASE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic              addr_i,
    input  logic [DW-1:0]     wdata_i,
    input  logic [N-1:0]      irr_i,
    input  logic [N-1:0]      isr_i,
    output logic [N-1:0]      mask_o,
    output logic [BASE_W-1:0] base_o,
    output logic              level_o,
    output logic              aeoi_o,
    output logic              eoi_o,
    output logic              rd_en_o,
    output logic [DW-1:0]     rdata_o
);

    typedef struct packed {
        logic [N-1:0]      mask;
        logic [BASE_W-1:0] base;
        logic              level;
        logic              aeoi;
        logic              rsel;
    } cfg_t;

    cfg_t r_q, r_d;
    logic wen;

    always_comb begin
        r_d   = r_q;
        eoi_o = 1'b0;
        wen   = cs_i & wr_i;
        if (wen) begin
            if (addr_i) begin
                r_d.mask = wdata_i[N-1:0];
            end else if (wdata_i[CMD_CFG_BIT]) begin
                r_d.base  = wdata_i[BASE_W-1:0];
                r_d.level = wdata_i[CFG_LVL_BIT];
                r_d.aeoi  = wdata_i[CFG_AEOI_BIT];
            end else if (wdata_i[CMD_EOI_BIT]) begin
                eoi_o = 1'b1;
            end else begin
                r_d.rsel = wdata_i[CMD_RSEL_BIT];
            end
        end
        rd_en_o = cs_i & rd_i;
        if (!rd_en_o)     rdata_o = '0;
        else if (addr_i)  rdata_o = DW'(r_q.mask);
        else if (r_q.rsel) rdata_o = DW'(isr_i);
        else              rdata_o = DW'(irr_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.mask  <= '1;
            r_q.base  <= '0;
            r_q.level <= 1'b0;
            r_q.aeoi  <= 1'b0;
            r_q.rsel  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mask_o  = r_q.mask;
    assign base_o  = r_q.base;
    assign level_o = r_q.level;
    assign aeoi_o  = r_q.aeoi;

    AST_MASK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_i && wr_i && addr_i) |=> (mask_o == $past(wdata_i[N-1:0]))); // R8

    AST_CFG_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_i && wr_i && !addr_i && wdata_i[CMD_CFG_BIT])
        |=> (base_o == $past(wdata_i[BASE_W-1:0]))); // R9

endmodule

// File: rtl/pri_irq_ctrl.sv
module pri_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int N_IRQ = 8,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq_req_i,
    output logic             irq_o,
    input  logic             ack_i,
    input  logic             bus_cs_i,
    input  logic             bus_rd_i,
    input  logic             bus_wr_i,
    input  logic             bus_addr_i,
    input  logic [DW-1:0]    bus_wdata_i,
    output logic [DW-1:0]    bus_rdata_o,
    output logic             bus_oe_o
);

    localparam int IW     = $clog2(N_IRQ);
    localparam int BASE_W = DW - IW;

    typedef struct packed {
        logic [N_IRQ-1:0] irr;
        logic [N_IRQ-1:0] isr;
        logic [N_IRQ-1:0] req;
        logic [IW-1:0]    idx;
        logic             spur;
    } core_t;

    core_t c_q, c_d;

    logic [N_IRQ-1:0]  mask, pend, p_oh, s_oh, aeoi_clr;
    logic [BASE_W-1:0] base;
    logic              level, aeoi, eoi, rd_en;
    logic [DW-1:0]     reg_rdata;
    logic              commit, drive, finish, busy;
    logic              p_found, s_found, win_found;
    logic [IW-1:0]     p_idx, s_idx;

    irqc_regs #(.N(N_IRQ), .DW(DW), .BASE_W(BASE_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_i    (bus_cs_i),
        .rd_i    (bus_rd_i),
        .wr_i    (bus_wr_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .irr_i   (c_q.irr),
        .isr_i   (c_q.isr),
        .mask_o  (mask),
        .base_o  (base),
        .level_o (level),
        .aeoi_o  (aeoi),
        .eoi_o   (eoi),
        .rd_en_o (rd_en),
        .rdata_o (reg_rdata)
    );

    irqc_ackseq u_ack (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_i    (ack_i),
        .commit_o (commit),
        .drive_o  (drive),
        .finish_o (finish),
        .busy_o   (busy)
    );

    assign pend = c_q.irr & ~mask;

    // Most urgent pending request
    irqc_prienc #(.N(N_IRQ), .IW(IW)) u_pend_enc (
        .vec_i      (pend),
        .found_o    (p_found),
        .idx_o      (p_idx),
        .first_oh_o (p_oh)
    );

    // Most urgent in-service level
    irqc_prienc #(.N(N_IRQ), .IW(IW)) u_svc_enc (
        .vec_i      (c_q.isr),
        .found_o    (s_found),
        .idx_o      (s_idx),
        .first_oh_o (s_oh)
    );

    // Request must strictly outrank every in-service level
    assign win_found = p_found & (~s_found | (p_idx < s_idx));
    assign irq_o     = win_found & ~busy;
    assign aeoi_clr  = {{(N_IRQ-1){1'b0}}, 1'b1} << c_q.idx;

    always_comb begin
        c_d     = c_q;
        c_d.req = irq_req_i;
        if (level) c_d.irr = irq_req_i;
        else       c_d.irr = c_q.irr | (irq_req_i & ~c_q.req);
        if (commit) begin
            if (win_found) begin
                c_d.irr  = c_d.irr & ~p_oh;
                c_d.isr  = c_d.isr | p_oh;
                c_d.idx  = p_idx;
                c_d.spur = 1'b0;
            end else begin
                c_d.idx  = '1;
                c_d.spur = 1'b1;
            end
        end
        if (eoi) c_d.isr = c_d.isr & ~s_oh;
        if (finish && aeoi && !c_q.spur) c_d.isr = c_d.isr & ~aeoi_clr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.irr  <= '0;
            c_q.isr  <= '0;
            c_q.req  <= '0;
            c_q.idx  <= '0;
            c_q.spur <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign bus_rdata_o = drive ? {base, c_q.idx} : reg_rdata;
    assign bus_oe_o    = drive | rd_en;

    AST_QUIET_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        commit ##1 ack_i |-> !drive); // R4

    AST_COMMIT_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && win_found) |=> c_q.isr[$past(p_idx)]); // R4

    AST_SPUR_KEEPS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !win_found && !eoi) |=> (c_q.isr == $past(c_q.isr))); // R11

    AST_AUTO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && aeoi && !c_q.spur) |=> !c_q.isr[$past(c_q.idx)]); // R6

    AST_EOI_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && (c_q.isr != '0) && !commit && !finish)
        |=> ($countones(c_q.isr) == $countones($past(c_q.isr)) - 1)); // R7

    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_q.irr & ~mask) == '0) |-> !irq_o); // R8

endmodule

// File: tb/test_pri_irq_ctrl.sv
`timescale 1ns/1ps
module test_pri_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] req;
    logic       ack, cs, rd, wr, addr;
    logic [7:0] wdata;
    logic       irq;
    logic [7:0] rdata;
    logic       oe;

    int n_vec = 0;
    int n_bad = 0;

    // Behavioural reference state
    logic [7:0] m_irr, m_isr, m_mask, m_req_q;
    logic [4:0] m_base;
    logic       m_level, m_aeoi, m_rsel, m_spur, m_ack_q;
    int         m_ph, m_idx;
    int         mw, mlo;
    logic [7:0] mnirr;
    logic       mrise, mfall;

    always #4 clk = ~clk;

    pri_irq_ctrl i_pri_irq_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_req_i   (req),
        .irq_o       (irq),
        .ack_i       (ack),
        .bus_cs_i    (cs),
        .bus_rd_i    (rd),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .bus_oe_o    (oe)
    );

    function automatic int m_win();
        for (int i = 0; i < 8; i++) begin
            if (m_isr[i]) return -1;
            if (m_irr[i] && !m_mask[i]) return i;
        end
        return -1;
    endfunction

    function automatic int m_low_isr();
        for (int i = 0; i < 8; i++) if (m_isr[i]) return i;
        return -1;
    endfunction

    task automatic note(string tag, logic [7:0] act, logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model update
    always @(posedge clk) begin
        if (!rst_n) begin
            m_irr = 0; m_isr = 0; m_mask = 8'hFF; m_req_q = 0; m_base = 0;
            m_level = 0; m_aeoi = 0; m_rsel = 0; m_spur = 0; m_ack_q = 0;
            m_ph = 0; m_idx = 0;
        end else begin
            mw    = m_win();
            mlo   = m_low_isr();
            mrise = ack && !m_ack_q;
            mfall = !ack && m_ack_q;
            mnirr = m_level ? req : (m_irr | (req & ~m_req_q));
            if (mrise && m_ph == 0) begin
                if (mw >= 0) begin
                    m_isr[mw] = 1'b1; mnirr[mw] = 1'b0; m_idx = mw; m_spur = 0;
                end else begin
                    m_idx = 7; m_spur = 1;
                end
                m_ph = 1;
            end else if (mrise && m_ph == 1) begin
                m_ph = 2;
            end else if (mfall && m_ph == 2) begin
                m_ph = 0;
                if (m_aeoi && !m_spur) m_isr[m_idx] = 1'b0;
            end
            if (cs && wr) begin
                if (addr) m_mask = wdata;
                else if (wdata[7]) begin
                    m_base = wdata[4:0]; m_level = wdata[5]; m_aeoi = wdata[6];
                end else if (wdata[6]) begin
                    if (mlo >= 0) m_isr[mlo] = 1'b0;
                end else m_rsel = wdata[0];
            end
            m_irr = mnirr; m_req_q = req; m_ack_q = ack;
        end
    end

    // Every-cycle comparison, away from the clock edge
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            logic e_irq, e_drv, e_rd;
            logic [7:0] e_dat;
            string tg;
            e_irq = (m_ph == 0) && (m_win() >= 0);
            e_drv = ack && (m_ph == 2 || (m_ph == 1 && !m_ack_q));
            e_rd  = cs && rd;
            if (e_drv)      e_dat = {m_base, 3'(m_idx)};
            else if (e_rd)  e_dat = addr ? m_mask : (m_rsel ? m_isr : m_irr);
            else            e_dat = 8'h00;
            if (e_drv)                    tg = "R5";
            else if (ack && m_ph == 1)    tg = "R4";
            else                          tg = "R10";
            note("R3", {7'b0, irq}, {7'b0, e_irq});
            note(tg, {7'b0, oe}, {7'b0, (e_drv || e_rd)});
            note(tg, rdata, e_dat);
        end
    end

    task automatic wr_reg(logic a, logic [7:0] d);
        @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
        @(negedge clk); cs = 0; wr = 0;
    endtask

    task automatic rd_reg(logic a, output logic [7:0] v);
        @(negedge clk); cs = 1; rd = 1; addr = a;
        #3 v = rdata;
        @(negedge clk); cs = 0; rd = 0;
    endtask

    task automatic rd_sel(logic sel, output logic [7:0] v);
        wr_reg(1'b0, {7'b0, sel});
        rd_reg(1'b0, v);
    endtask

    task automatic eoi_cmd();
        wr_reg(1'b0, 8'h40);
    endtask

    task automatic ack_seq(output logic [7:0] v, output logic q1);
        @(negedge clk); ack = 1;
        @(negedge clk); #3 q1 = oe;
        @(negedge clk); ack = 0;
        @(negedge clk); ack = 1;
        #3 v = rdata;
        @(negedge clk);
        @(negedge clk); ack = 0;
        @(negedge clk);
    endtask

    task automatic chk_irq(logic e, string tag);
        @(negedge clk); #3;
        note(tag, {7'b0, irq}, {7'b0, e});
    endtask

    task automatic pulse_req(logic [7:0] r);
        @(negedge clk); req = r;
        @(negedge clk); req = 0;
    endtask

    initial begin
        logic [7:0] v;
        logic       q;
        rst_n = 0; req = 0; ack = 0; cs = 0; rd = 0; wr = 0; addr = 0; wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #3;
        note("R12", {7'b0, irq}, 8'h00);
        note("R12", {7'b0, oe}, 8'h00);
        rd_reg(1'b1, v);  note("R12", v, 8'hFF);
        rd_sel(1'b0, v);  note("R10", v, 8'h00);

        // Edge mode, base 0x12, manual release; unmask all
        wr_reg(1'b0, 8'h92);
        wr_reg(1'b1, 8'h00);
        pulse_req(8'h08);
        chk_irq(1'b1, "R3");
        rd_sel(1'b0, v);  note("R1", v, 8'h08);
        ack_seq(v, q);
        note("R4", {7'b0, q}, 8'h00);
        note("R5", v, 8'h93);
        note("R9", {3'b0, v[7:3]}, 8'h12);
        rd_sel(1'b1, v);  note("R4", v, 8'h08);
        rd_sel(1'b0, v);  note("R4", v, 8'h00);

        // Nesting: inputs 1 and 5 arrive while 3 is in service
        pulse_req(8'h22);
        chk_irq(1'b1, "R3");
        ack_seq(v, q);
        note("R3", v, 8'h91);
        note("R4", {7'b0, q}, 8'h00);
        rd_sel(1'b1, v);  note("R7", v, 8'h0A);
        chk_irq(1'b0, "R3");
        eoi_cmd();
        rd_sel(1'b1, v);  note("R7", v, 8'h08);
        chk_irq(1'b0, "R3");
        eoi_cmd();
        rd_sel(1'b1, v);  note("R7", v, 8'h00);
        chk_irq(1'b1, "R3");
        ack_seq(v, q);
        note("R3", v, 8'h95);
        eoi_cmd();
        rd_sel(1'b1, v);  note("R7", v, 8'h00);

        // Masking
        wr_reg(1'b1, 8'h04);
        pulse_req(8'h04);
        chk_irq(1'b0, "R8");
        rd_sel(1'b0, v);  note("R8", v, 8'h04);
        rd_reg(1'b1, v);  note("R8", v, 8'h04);
        wr_reg(1'b1, 8'h00);
        chk_irq(1'b1, "R8");
        ack_seq(v, q);
        note("R8", v, 8'h92);
        eoi_cmd();

        // Level mode with automatic release, base 0x05
        wr_reg(1'b0, 8'hE5);
        @(negedge clk); req = 8'h50;
        chk_irq(1'b1, "R2");
        rd_sel(1'b0, v);  note("R2", v, 8'h50);
        ack_seq(v, q);
        note("R5", v, 8'h2C);
        note("R4", {7'b0, q}, 8'h00);
        rd_sel(1'b1, v);  note("R6", v, 8'h00);
        @(negedge clk); req = 8'h00;
        chk_irq(1'b0, "R2");
        rd_sel(1'b0, v);  note("R2", v, 8'h00);

        // Request withdrawn before acknowledge
        @(negedge clk); req = 8'h04;
        chk_irq(1'b1, "R11");
        @(negedge clk); req = 8'h00;
        chk_irq(1'b0, "R11");
        ack_seq(v, q);
        note("R11", v, 8'h2F);
        rd_sel(1'b1, v);  note("R11", v, 8'h00);

        // Edge mode with a held input: one acknowledge only
        wr_reg(1'b0, 8'h92);
        @(negedge clk); req = 8'h01;
        chk_irq(1'b1, "R1");
        ack_seq(v, q);
        note("R1", v, 8'h90);
        rd_sel(1'b0, v);  note("R1", v, 8'h00);
        eoi_cmd();
        chk_irq(1'b0, "R1");
        @(negedge clk); req = 8'h00;
        repeat (3) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule